// File: doc/BRIEF.md
# Bidirectional Latch/Register Bus Transceiver

This block connects two 18-bit buses, called A and B, and carries data between them in either direction. Each direction has its own storage element and three controls: a latch enable, a capture strobe and an output enable. With the latch enable high, data passes straight through. With it low, the element holds its content, and a high-to-low transition of the strobe loads the current input. The output enable decides whether that direction drives its destination bus or leaves it in high impedance. The A-to-B enable is active high. The B-to-A enable is active low.

The block sits in a synchronous design, so a free-running system clock samples the strobes. A strobe fall seen between two system clock edges is captured at the second of those edges. While the latch enable is high, the storage element also reloads on every system clock edge. When the latch enable falls, the element therefore keeps the value present at the last edge before the fall. The transparent path itself is combinational, so the output follows the input in the same cycle. Both buses are inout ports with tri-state drivers. The user must keep the two output enables from driving at the same time.

Top module: `xcvr_bidir_top`

## Requirements
- R1: With `a2b_le` high and `a2b_oe` high, `b_bus` equals `a_bus` in the same cycle, without waiting for a clock edge.
- R2: With `a2b_le` low and no falling edge on `a2b_stb`, the A-to-B stored value stays unchanged while `a_bus` changes, and `b_bus` shows the stored value.
- R3: With `a2b_le` low, a high-to-low change of `a2b_stb` loads `a_bus` into the A-to-B element at the next rising edge of `clk`. The new value appears on `b_bus` from that edge on.
- R4: A low-to-high change of `a2b_stb` leaves the A-to-B stored value unchanged.
- R5: With `a2b_oe` low, the block does not drive `b_bus`; an outside driver's value is read back unchanged. Setting `a2b_oe` high again shows the stored value.
- R6: `a_bus` is driven only while `b2a_oe_n` is low. With `b2a_oe_n` high, an outside driver's value is read back unchanged.
- R7: The B-to-A direction follows R1 to R4 using `b2a_le` and `b2a_stb`, taking data from `b_bus` and showing it on `a_bus`.
- R8: Capture, hold and transparent operation in one direction never changes the value stored in the other direction.
- R9: While `rst_n` is low, both stored values are zero. A direction whose output is enabled with its latch enable low then drives zero.
- R10: When the latch enable of a direction falls, the element keeps the input value present at the last rising `clk` edge while the enable was high.
- R11: A falling strobe while the latch enable is high has no effect beyond the transparent path; the output keeps following the live input.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples strobes and updates the storage |
| rst_n | input | 1 | Asynchronous active-low reset |
| a2b_le | input | 1 | A-to-B latch enable, high = transparent |
| a2b_stb | input | 1 | A-to-B capture strobe, captures on its falling edge |
| a2b_oe | input | 1 | A-to-B output enable, active high, drives `b_bus` |
| b2a_le | input | 1 | B-to-A latch enable, high = transparent |
| b2a_stb | input | 1 | B-to-A capture strobe, captures on its falling edge |
| b2a_oe_n | input | 1 | B-to-A output enable, active low, drives `a_bus` |
| a_bus | inout | 18 | A-side bus |
| b_bus | inout | 18 | B-side bus |

## Verification
The assertions assume the environment never enables both output directions at the same rising clock edge. They also assume that a bus feeding a storage element carries a driven value whenever that element samples it. The bench meets both conditions. It switches direction by releasing one output enable and its own driver before it enables the other side. It drives data and strobes only on the falling system clock edge, so every level is settled well before the next capturing edge.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

  typedef enum logic [1:0] {
    CAP_HOLD   = 2'd0,
    CAP_FOLLOW = 2'd1,
    CAP_EDGE   = 2'd2
  } cap_mode_e;

  // Latch enable dominates; a strobe fall matters only while the element is opaque.
  function automatic cap_mode_e pick_mode(input logic le, input logic fall);
    if (le)        return CAP_FOLLOW;
    else if (fall) return CAP_EDGE;
    else           return CAP_HOLD;
  endfunction

  // Output enable decode for either polarity.
  function automatic logic drive_on(input logic oe_pin, input logic active_high);
    return (oe_pin == active_high);
  endfunction

endpackage

// File: rtl/xcvr_fall_det.sv
module xcvr_fall_det (
  input  logic clk,
  input  logic rst_n,
  input  logic stb,
  output logic fall
);
  logic stb_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stb_q <= 1'b0;
    else        stb_q <= stb;
  end

  assign fall = stb_q & ~stb;
endmodule

// File: rtl/xcvr_store.sv
module xcvr_store
  import xcvr_pkg::*;
#(
  parameter int W = 18
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         le,
  input  logic         stb,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout,
  output logic [W-1:0] held,
  output logic         fall_evt
);
  cap_mode_e mode;

  xcvr_fall_det u_fall (
    .clk  (clk),
    .rst_n(rst_n),
    .stb  (stb),
    .fall (fall_evt)
  );

  assign mode = pick_mode(le, fall_evt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held <= '0;
    end else begin
      case (mode)
        CAP_FOLLOW, CAP_EDGE: held <= din;
        default:              held <= held;
      endcase
    end
  end

  // Transparent path bypasses the register combinationally.
  assign dout = le ? din : held;
endmodule

// File: rtl/xcvr_drv.sv
module xcvr_drv
  import xcvr_pkg::*;
#(
  parameter bit OE_ACTIVE_HIGH = 1'b1
) (
  input  logic oe_pin,
  output logic drv_en
);
  assign drv_en = drive_on(oe_pin, OE_ACTIVE_HIGH);
endmodule

// File: rtl/xcvr_bidir_top.sv
module xcvr_bidir_top #(
  parameter int W = 18
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         a2b_le,
  input  logic         a2b_stb,
  input  logic         a2b_oe,
  input  logic         b2a_le,
  input  logic         b2a_stb,
  input  logic         b2a_oe_n,
  inout  wire  [W-1:0] a_bus,
  inout  wire  [W-1:0] b_bus
);
  localparam int NDIR = 2;
  // Index 0 = A-to-B, index 1 = B-to-A.
  localparam bit [NDIR-1:0] OE_POL = 2'b01;

  logic [NDIR-1:0] le_v, stb_v, oe_v, en_v, fall_v;
  logic [W-1:0]    src   [NDIR];
  logic [W-1:0]    out_v [NDIR];
  logic [W-1:0]    held_v[NDIR];

  // Named internal events for the bound checker.
  logic         a2b_fall, b2a_fall;
  logic [W-1:0] a2b_q, b2a_q;

  assign le_v  = {b2a_le,   a2b_le};
  assign stb_v = {b2a_stb,  a2b_stb};
  assign oe_v  = {b2a_oe_n, a2b_oe};
  assign src[0] = a_bus;
  assign src[1] = b_bus;

  for (genvar d = 0; d < NDIR; d++) begin : g_dir
    xcvr_store #(.W(W)) u_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .le      (le_v[d]),
      .stb     (stb_v[d]),
      .din     (src[d]),
      .dout    (out_v[d]),
      .held    (held_v[d]),
      .fall_evt(fall_v[d])
    );
    xcvr_drv #(.OE_ACTIVE_HIGH(OE_POL[d])) u_drv (
      .oe_pin(oe_v[d]),
      .drv_en(en_v[d])
    );
  end

  assign b_bus = en_v[0] ? out_v[0] : {W{1'bz}};
  assign a_bus = en_v[1] ? out_v[1] : {W{1'bz}};

  assign a2b_fall = fall_v[0];
  assign b2a_fall = fall_v[1];
  assign a2b_q    = held_v[0];
  assign b2a_q    = held_v[1];
endmodule

// File: rtl/xcvr_bidir_chk.sv
module xcvr_bidir_chk #(
  parameter int W = 18
) (
  input logic         clk,
  input logic         rst_n,
  input logic         a2b_le,
  input logic         a2b_oe,
  input logic         b2a_le,
  input logic         b2a_oe_n,
  input logic [W-1:0] a_bus,
  input logic [W-1:0] b_bus,
  input logic         a2b_fall,
  input logic         b2a_fall,
  input logic [W-1:0] a2b_q,
  input logic [W-1:0] b2a_q
);
  assert_transp_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (a2b_oe && a2b_le) |-> (b_bus === a_bus));

  assert_follow_store_R10: assert property (@(posedge clk) disable iff (!rst_n)
    a2b_le |=> (a2b_q == $past(a_bus)));

  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!a2b_le && !a2b_fall) |=> $stable(a2b_q));

  assert_capture_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!a2b_le && a2b_fall) |=> (a2b_q == $past(a_bus)));

  assert_ba_transp_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!b2a_oe_n && b2a_le) |-> (a_bus === b_bus));

  assert_ba_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!b2a_le && !b2a_fall) |=> $stable(b2a_q));

  assert_ba_capture_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!b2a_le && b2a_fall) |=> (b2a_q == $past(b_bus)));

  // Environment rule: at most one direction drives (R5, R6).
  assert_one_driver_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(a2b_oe && !b2a_oe_n));
endmodule

bind xcvr_bidir_top xcvr_bidir_chk #(.W(W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .a2b_le  (a2b_le),
  .a2b_oe  (a2b_oe),
  .b2a_le  (b2a_le),
  .b2a_oe_n(b2a_oe_n),
  .a_bus   (a_bus),
  .b_bus   (b_bus),
  .a2b_fall(a2b_fall),
  .b2a_fall(b2a_fall),
  .a2b_q   (a2b_q),
  .b2a_q   (b2a_q)
);

// File: tb/tb_xcvr_bidir_top.sv
`timescale 1ns/1ps
module tb_xcvr_bidir_top;
  localparam int W = 18;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic a2b_le = 0, a2b_stb = 0, a2b_oe = 0;
  logic b2a_le = 0, b2a_stb = 0, b2a_oe_n = 1;
  logic         tb_a_en = 0, tb_b_en = 0;
  logic [W-1:0] tb_a_val = '0, tb_b_val = '0;
  wire  [W-1:0] a_bus, b_bus;
  int errors = 0;
  int checks = 0;

  assign a_bus = tb_a_en ? tb_a_val : {W{1'bz}};
  assign b_bus = tb_b_en ? tb_b_val : {W{1'bz}};

  always #10 clk = ~clk;

  xcvr_bidir_top #(.W(W)) dut (
    .clk(clk), .rst_n(rst_n),
    .a2b_le(a2b_le), .a2b_stb(a2b_stb), .a2b_oe(a2b_oe),
    .b2a_le(b2a_le), .b2a_stb(b2a_stb), .b2a_oe_n(b2a_oe_n),
    .a_bus(a_bus), .b_bus(b_bus)
  );

  task automatic chk(input string req, input logic [W-1:0] got, input logic [W-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic report();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  task automatic t_reset();
    a2b_oe = 1; tb_a_en = 1; tb_a_val = 18'h2AAAA;
    #2 chk("R9 a2b reset", b_bus, '0);
    a2b_oe = 0; tb_a_en = 0;
    tb_b_en = 1; tb_b_val = 18'h15555; b2a_oe_n = 0;
    #2 chk("R9 b2a reset", a_bus, '0);
    b2a_oe_n = 1; tb_b_en = 0;
    step(1); rst_n = 1; step(1);
  endtask

  task automatic t_a2b();
    b2a_oe_n = 1; tb_b_en = 0; tb_a_en = 1; a2b_oe = 1;
    a2b_le = 1; tb_a_val = 18'h01234;
    #2 chk("R1 pass", b_bus, 18'h01234);
    tb_a_val = 18'h03F00;
    #2 chk("R1 pass live", b_bus, 18'h03F00);
    step(1);
    a2b_le = 0; tb_a_val = 18'h00055;
    #2 chk("R10 keep last", b_bus, 18'h03F00);
    step(1); #2 chk("R2 hold", b_bus, 18'h03F00);
    a2b_stb = 1; step(1);
    a2b_stb = 0; tb_a_val = 18'h02468; step(1);
    #2 chk("R3 capture", b_bus, 18'h02468);
    tb_a_val = '0; step(3);
    #2 chk("R2 hold after capture", b_bus, 18'h02468);
    a2b_stb = 1; tb_a_val = 18'h01111; step(2);
    #2 chk("R4 rising ignored", b_bus, 18'h02468);
    a2b_stb = 0; tb_a_val = 18'h00ABC; step(1);
    #2 chk("R3 second capture", b_bus, 18'h00ABC);
    a2b_stb = 1; step(1);
    a2b_stb = 0; tb_a_val = 18'h3FFFF; step(1);
    a2b_oe = 0; tb_b_en = 1; tb_b_val = '0;
    #2 chk("R5 b released", b_bus, '0);
    tb_b_en = 0; a2b_oe = 1;
    #2 chk("R5 re-enabled", b_bus, 18'h3FFFF);
    a2b_le = 1; tb_a_val = 18'h00F0F; a2b_stb = 1; step(1);
    a2b_stb = 0; step(1);
    #2 chk("R11 fall while open", b_bus, 18'h00F0F);
    tb_a_val = 18'h03030;
    #2 chk("R11 still live", b_bus, 18'h03030);
    step(1);
    a2b_le = 0; a2b_oe = 0; tb_a_en = 0;
  endtask

  task automatic t_b2a();
    a2b_oe = 0; tb_a_en = 0; tb_b_en = 1; b2a_oe_n = 0;
    b2a_le = 1; tb_b_val = 18'h04321;
    #2 chk("R7 pass", a_bus, 18'h04321);
    step(1);
    b2a_le = 0; tb_b_val = 18'h00077;
    #2 chk("R7 keep last", a_bus, 18'h04321);
    step(2); #2 chk("R7 hold", a_bus, 18'h04321);
    b2a_stb = 1; step(1);
    b2a_stb = 0; tb_b_val = 18'h13579; step(1);
    #2 chk("R7 capture", a_bus, 18'h13579);
    b2a_stb = 1; tb_b_val = 18'h02222; step(2);
    #2 chk("R7 rising ignored", a_bus, 18'h13579);
    b2a_stb = 0; tb_b_val = 18'h3FFFF; step(1);
    b2a_oe_n = 1; tb_a_en = 1; tb_a_val = '0;
    #2 chk("R6 a released", a_bus, '0);
    tb_a_en = 0; b2a_oe_n = 0;
    #2 chk("R6 a driven", a_bus, 18'h3FFFF);
    b2a_stb = 1; step(1);
    b2a_stb = 0; tb_b_val = 18'h00C0C; step(1);
    b2a_oe_n = 1; tb_b_en = 0;
  endtask

  task automatic t_indep();
    tb_a_en = 1; tb_a_val = 18'h155AA;
    a2b_stb = 1; step(1);
    a2b_stb = 0; step(1);
    tb_a_en = 0; tb_b_en = 1; tb_b_val = '0; b2a_oe_n = 0;
    #2 chk("R8 b2a untouched", a_bus, 18'h00C0C);
    b2a_oe_n = 1; tb_b_en = 0; tb_a_en = 1; tb_a_val = '0; a2b_oe = 1;
    #2 chk("R8 a2b captured", b_bus, 18'h155AA);
    step(1);
    a2b_oe = 0; tb_a_en = 0;
  endtask

  initial begin
    step(1);
    t_reset();
    t_a2b();
    step(1);
    t_b2a();
    step(1);
    t_indep();
    step(2);
    report();
  end

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog: got=timeout expected=completion");
    report();
  end
endmodule